// File: doc/BRIEF.md
# Flash Byte Program Sequencer

This block writes a run of bytes into one erase block of a byte-programmable flash device and then proves the result by reading it back. A requester pulses a start strobe with a start address and a byte count. The block limits the count to the bytes left before the next erase-block boundary. It then takes exactly that many bytes from a ready/valid source into a local buffer. Each byte then gets its own command sequence on a simple one-cycle flash bus, and the block retries bytes that the device fails to accept.

Every gated command group begins with a one-cycle write-gate pulse and a settle delay. After the gate, the block sends the program command, the data byte and a status request, and then polls the status byte. Two failure paths lead to a retry. A poll that runs past its per-byte limit clears status and repeats the byte, with no overall limit. A device error flag also causes a retry, but only while a deadline that covers the whole block has not passed. When the deadline has passed, the run aborts. After the last byte and a short wait, every byte is read back and compared with the buffer. The requester receives the number of bytes written and a result code.

The erase-block size is `2**BLOCK_W` bytes. A device with 64 KiB blocks uses `BLOCK_W = 16`. The default is smaller, to keep the buffer small. All delays are parameterised cycle counts.

Top module: `flash_prog_seq`

## Requirements
- R1: On start, the clipped count is min(byteCount, 2**BLOCK_W − (startAddr mod 2**BLOCK_W)). The run never goes past the end of the block.
- R2: `inReady` is high only while the buffer is filling. Exactly the clipped count of bytes is taken from the source, in order.
- R3: Each program attempt is a `gateOpen` pulse, then at least SETTLE_CYC idle cycles, then three consecutive bus writes: 0x40, the data byte, and 0x70. Each write goes to the word-aligned byte address (`flashAddr[1:0]` = 0), with `laneSel` carrying the low two address bits. The 0xFF and 0x50 commands are also preceded by a gate pulse.
- R4: After 0x70, status is read every cycle until bit 7 is set. If bit 7 stays clear for BYTE_TO_CYC polls, the block writes 0x50 and repeats the same byte. This retry does not depend on the deadline.
- R5: When bit 7 is seen, the block writes 0xFF. If the latched status bit 4 was set, the block writes 0x50, waits RETRY_WAIT_CYC cycles, and retries the same byte.
- R6: A device error found after BLOCK_TO_CYC cycles of programming (counted from the end of the fill) ends the run with errCode 2 and bytesWritten 0.
- R7: After all bytes are programmed and VERIFY_WAIT_CYC cycles pass, each byte is read back at its own address. The first mismatch ends the run with errCode 1 and bytesWritten 0.
- R8: A run that succeeds ends with errCode 0 and bytesWritten equal to the clipped count. `done` is a one-cycle pulse and `busy` is low when it occurs. Both results hold until the next run.
- R9: A clipped count of zero ends the run with no flash bus write and bytesWritten 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start pulse, taken when idle |
| startAddr | input | ADDR_W | First byte address |
| byteCount | input | BLOCK_W+1 | Requested byte count |
| inData | input | 8 | Source byte |
| inValid | input | 1 | Source byte valid |
| inReady | output | 1 | Block takes a byte this cycle |
| flashAddr | output | ADDR_W | Flash bus address |
| flashWrData | output | 8 | Flash bus write byte |
| flashWe | output | 1 | One-cycle bus write |
| flashRe | output | 1 | Bus read; data sampled the same cycle |
| flashRdData | input | 8 | Flash read data |
| laneSel | output | 2 | Byte lane within the word |
| gateOpen | output | 1 | Write-gate open pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished pulse |
| bytesWritten | output | BLOCK_W+1 | Bytes written by the last run |
| errCode | output | 2 | 0 ok, 1 verify mismatch, 2 deadline abort |

## Verification
The bench drives the block against a behavioural flash model. The model can stall status for a set number of attempts, raise the error flag for a set number of attempts, or corrupt one stored byte. Runs placed in the middle of a block, runs that cross the boundary, runs that end exactly at the boundary, runs that start on the last byte, and zero-length runs test the clipping arithmetic. Stalled and error attempts are counted through the 0x40 and 0x50 writes seen on the bus, which shows whether the timeout retry and the device-error retry each repeat the right byte. An endless error flag separates the deadline abort from an ordinary retry. The corrupted byte separates a verify mismatch from a successful run. Random addresses, counts and data check that every byte lands in its lane and that no byte outside the range changes.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_CMD_PROG,
    BUS_DATA,
    BUS_CMD_STAT,
    BUS_CMD_CLR,
    BUS_CMD_READ,
    BUS_RD_STAT,
    BUS_RD_BYTE
  } busOp_e;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_VERIFY = 2'd1,
    RES_ABORT  = 2'd2
  } result_e;

  localparam logic [7:0] OPC_PROG = 8'h40;
  localparam logic [7:0] OPC_STAT = 8'h70;
  localparam logic [7:0] OPC_CLR  = 8'h50;
  localparam logic [7:0] OPC_READ = 8'hFF;

  typedef struct packed {
    logic    start;
    logic    bufWr;
    logic    idxClr;
    logic    idxInc;
    logic    waitClr;
    logic    dlRun;
    logic    statLatch;
    logic    gate;
    logic    finish;
    result_e finishCode;
    busOp_e  busOp;
  } ctlStrobe_t;

  typedef struct packed {
    logic cntZero;
    logic idxLast;
    logic settleDone;
    logic byteTimeout;
    logic retryDone;
    logic verifyDone;
    logic deadlineHit;
    logic statReady;
    logic statErr;
    logic rdMatch;
  } dpFlag_t;

endpackage

// File: rtl/flash_prog_dp.sv
module flash_prog_dp
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W          = 12,
  parameter int BLOCK_W         = 8,
  parameter int SETTLE_CYC      = 4,
  parameter int BYTE_TO_CYC     = 64,
  parameter int RETRY_WAIT_CYC  = 8,
  parameter int VERIFY_WAIT_CYC = 8,
  parameter int BLOCK_TO_CYC    = 2000
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic [BLOCK_W:0]    byteCount,
  input  logic [7:0]          inData,
  input  logic [7:0]          flashRdData,
  output dpFlag_t             flags,
  output logic [ADDR_W-1:0]   flashAddr,
  output logic [7:0]          flashWrData,
  output logic                flashWe,
  output logic                flashRe,
  output logic [1:0]          laneSel,
  output logic [BLOCK_W:0]    bytesWritten,
  output logic [1:0]          errCode
);

  localparam int CNT_W       = BLOCK_W + 1;
  localparam int BLOCK_BYTES = 1 << BLOCK_W;
  localparam int HI_W        = ADDR_W - BLOCK_W;
  localparam int T_A         = (SETTLE_CYC > BYTE_TO_CYC) ? SETTLE_CYC : BYTE_TO_CYC;
  localparam int T_B         = (RETRY_WAIT_CYC > VERIFY_WAIT_CYC) ? RETRY_WAIT_CYC : VERIFY_WAIT_CYC;
  localparam int T_MAX       = (T_A > T_B) ? T_A : T_B;
  localparam int TIMER_W     = $clog2(T_MAX + 1);
  localparam int DL_W        = $clog2(BLOCK_TO_CYC + 1);

  logic [HI_W-1:0]    baseHi;
  logic [BLOCK_W-1:0] startOff;
  logic [CNT_W-1:0]   clipCnt;
  logic [CNT_W-1:0]   idx;
  logic [TIMER_W-1:0] waitCnt;
  logic [DL_W-1:0]    dlCnt;
  logic               statErrReg;
  logic [7:0]         bufMem [BLOCK_BYTES];

  logic [CNT_W-1:0]   roomLeft;
  logic [BLOCK_W-1:0] curOff;
  logic [ADDR_W-1:0]  curAddr;
  logic [7:0]         bufByte;

  assign roomLeft = CNT_W'(BLOCK_BYTES) - {1'b0, startAddr[BLOCK_W-1:0]};
  assign curOff   = startOff + idx[BLOCK_W-1:0];
  assign curAddr  = {baseHi, curOff};
  assign bufByte  = bufMem[idx[BLOCK_W-1:0]];

  // run registers, index and timers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi     <= '0;
      startOff   <= '0;
      clipCnt    <= '0;
      idx        <= '0;
      waitCnt    <= '0;
      dlCnt      <= '0;
      statErrReg <= 1'b0;
    end else begin
      if (ctl.start) begin
        baseHi   <= startAddr[ADDR_W-1:BLOCK_W];
        startOff <= startAddr[BLOCK_W-1:0];
        clipCnt  <= (byteCount > roomLeft) ? roomLeft : byteCount;
        idx      <= '0;
        dlCnt    <= '0;
      end else begin
        if (ctl.idxClr)      idx <= '0;
        else if (ctl.idxInc) idx <= idx + 1'b1;
        if (ctl.dlRun && dlCnt < DL_W'(BLOCK_TO_CYC)) dlCnt <= dlCnt + 1'b1;
      end
      if (ctl.waitClr)                        waitCnt <= '0;
      else if (waitCnt < TIMER_W'(T_MAX))     waitCnt <= waitCnt + 1'b1;
      if (ctl.statLatch) statErrReg <= flashRdData[4];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.bufWr) bufMem[idx[BLOCK_W-1:0]] <= inData;
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bytesWritten <= '0;
      errCode      <= RES_OK;
    end else if (ctl.start) begin
      bytesWritten <= '0;
      errCode      <= RES_OK;
    end else if (ctl.finish) begin
      bytesWritten <= (ctl.finishCode == RES_OK) ? clipCnt : '0;
      errCode      <= ctl.finishCode;
    end
  end

  // flags to the controller
  always_comb begin
    flags.cntZero     = (clipCnt == '0);
    flags.idxLast     = (idx == clipCnt - 1'b1);
    flags.settleDone  = (waitCnt >= TIMER_W'(SETTLE_CYC - 1));
    flags.byteTimeout = (waitCnt >= TIMER_W'(BYTE_TO_CYC - 1));
    flags.retryDone   = (waitCnt >= TIMER_W'(RETRY_WAIT_CYC - 1));
    flags.verifyDone  = (waitCnt >= TIMER_W'(VERIFY_WAIT_CYC - 1));
    flags.deadlineHit = (dlCnt >= DL_W'(BLOCK_TO_CYC));
    flags.statReady   = flashRdData[7];
    flags.statErr     = statErrReg;
    flags.rdMatch     = (flashRdData == bufByte);
  end

  // flash bus drive
  always_comb begin
    flashWe     = 1'b0;
    flashRe     = 1'b0;
    flashWrData = 8'h00;
    flashAddr   = '0;
    laneSel     = 2'b00;
    if (ctl.busOp != BUS_IDLE) begin
      laneSel   = curAddr[1:0];
      flashAddr = {curAddr[ADDR_W-1:2], 2'b00};
    end
    unique case (ctl.busOp)
      BUS_CMD_PROG: begin flashWe = 1'b1; flashWrData = OPC_PROG; end
      BUS_DATA:     begin flashWe = 1'b1; flashWrData = bufByte;  end
      BUS_CMD_STAT: begin flashWe = 1'b1; flashWrData = OPC_STAT; end
      BUS_CMD_CLR:  begin flashWe = 1'b1; flashWrData = OPC_CLR;  end
      BUS_CMD_READ: begin flashWe = 1'b1; flashWrData = OPC_READ; end
      BUS_RD_STAT:  flashRe = 1'b1;
      BUS_RD_BYTE:  begin flashRe = 1'b1; flashAddr = curAddr; end
      default: ;
    endcase
  end

  // R1: the clipped run stays inside the block and never exceeds the request
  assert_clip_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.start) |-> ({1'b0, startOff} + {1'b0, clipCnt}) <= (CNT_W+1)'(BLOCK_BYTES));
  assert_clip_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.start) |-> clipCnt <= $past(byteCount));
  // R2: the controller never stores past the clipped count
  assert_fill_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.bufWr |-> idx < clipCnt);
  // R3: every bus write is word aligned
  assert_word_align_R3: assert property (@(posedge clk) disable iff (!rstN)
    flashWe |-> flashAddr[1:0] == 2'b00);
  // R6: an abort only happens once the deadline counter has run out
  assert_abort_deadline_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && ctl.finishCode == RES_ABORT) |-> flags.deadlineHit);

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       inValid,
  input  dpFlag_t    flags,
  output ctlStrobe_t ctl,
  output logic       inReady,
  output logic       busy,
  output logic       done
);

  typedef enum logic [3:0] {
    S_IDLE, S_FILL, S_GATE, S_SETTLE, S_PROG, S_DATA, S_STAT,
    S_POLL, S_READ, S_CLEAR, S_ERRWAIT, S_VWAIT, S_VREAD
  } state_e;

  state_e state, nextState, afterGate, nextAfter;
  logic   errCause, nextCause;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      afterGate <= S_PROG;
      errCause  <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= nextState;
      afterGate <= nextAfter;
      errCause  <= nextCause;
      done      <= ctl.finish;
    end
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    ctl       = '0;
    inReady   = 1'b0;
    nextState = state;
    nextAfter = afterGate;
    nextCause = errCause;
    ctl.dlRun = (state != S_IDLE) && (state != S_FILL);
    unique case (state)
      S_IDLE: if (startReq) begin
        ctl.start = 1'b1;
        nextState = S_FILL;
      end
      S_FILL: begin
        if (flags.cntZero) begin
          ctl.finish     = 1'b1;
          ctl.finishCode = RES_OK;
          nextState      = S_IDLE;
        end else begin
          inReady = 1'b1;
          if (inValid) begin
            ctl.bufWr = 1'b1;
            if (flags.idxLast) begin
              ctl.idxClr = 1'b1;
              nextAfter  = S_PROG;
              nextState  = S_GATE;
            end else begin
              ctl.idxInc = 1'b1;
            end
          end
        end
      end
      S_GATE: begin
        ctl.gate    = 1'b1;
        ctl.waitClr = 1'b1;
        nextState   = S_SETTLE;
      end
      S_SETTLE: if (flags.settleDone) nextState = afterGate;
      S_PROG: begin
        ctl.busOp = BUS_CMD_PROG;
        nextState = S_DATA;
      end
      S_DATA: begin
        ctl.busOp = BUS_DATA;
        nextState = S_STAT;
      end
      S_STAT: begin
        ctl.busOp   = BUS_CMD_STAT;
        ctl.waitClr = 1'b1;
        nextState   = S_POLL;
      end
      S_POLL: begin
        ctl.busOp = BUS_RD_STAT;
        if (flags.statReady) begin
          ctl.statLatch = 1'b1;
          nextAfter     = S_READ;
          nextState     = S_GATE;
        end else if (flags.byteTimeout) begin
          nextCause = 1'b0;
          nextAfter = S_CLEAR;
          nextState = S_GATE;
        end
      end
      S_READ: begin
        ctl.busOp = BUS_CMD_READ;
        if (flags.statErr) begin
          nextCause = 1'b1;
          nextAfter = S_CLEAR;
          nextState = S_GATE;
        end else if (flags.idxLast) begin
          ctl.idxClr  = 1'b1;
          ctl.waitClr = 1'b1;
          nextState   = S_VWAIT;
        end else begin
          ctl.idxInc = 1'b1;
          nextAfter  = S_PROG;
          nextState  = S_GATE;
        end
      end
      S_CLEAR: begin
        ctl.busOp = BUS_CMD_CLR;
        if (!errCause) begin
          nextAfter = S_PROG;
          nextState = S_GATE;
        end else if (flags.deadlineHit) begin
          ctl.finish     = 1'b1;
          ctl.finishCode = RES_ABORT;
          nextState      = S_IDLE;
        end else begin
          ctl.waitClr = 1'b1;
          nextState   = S_ERRWAIT;
        end
      end
      S_ERRWAIT: if (flags.retryDone) begin
        nextAfter = S_PROG;
        nextState = S_GATE;
      end
      S_VWAIT: if (flags.verifyDone) nextState = S_VREAD;
      S_VREAD: begin
        ctl.busOp = BUS_RD_BYTE;
        if (!flags.rdMatch) begin
          ctl.finish     = 1'b1;
          ctl.finishCode = RES_VERIFY;
          nextState      = S_IDLE;
        end else if (flags.idxLast) begin
          ctl.finish     = 1'b1;
          ctl.finishCode = RES_OK;
          nextState      = S_IDLE;
        end else begin
          ctl.idxInc = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  // R3: a program command only leaves the settle wait, and data follows it
  assert_prog_after_settle_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busOp == BUS_CMD_PROG |-> $past(state) == S_SETTLE);
  assert_data_after_prog_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busOp == BUS_DATA |-> $past(ctl.busOp) == BUS_CMD_PROG);
  // R4: polling begins straight after the status request
  assert_poll_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busOp == BUS_RD_STAT && $past(ctl.busOp) != BUS_RD_STAT) |-> $past(ctl.busOp) == BUS_CMD_STAT);
  // R8: done is a single-cycle pulse with the block idle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W          = 12,
  parameter int BLOCK_W         = 8,
  parameter int SETTLE_CYC      = 4,
  parameter int BYTE_TO_CYC     = 64,
  parameter int RETRY_WAIT_CYC  = 8,
  parameter int VERIFY_WAIT_CYC = 8,
  parameter int BLOCK_TO_CYC    = 2000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [ADDR_W-1:0]  startAddr,
  input  logic [BLOCK_W:0]   byteCount,
  input  logic [7:0]         inData,
  input  logic               inValid,
  output logic               inReady,
  output logic [ADDR_W-1:0]  flashAddr,
  output logic [7:0]         flashWrData,
  output logic               flashWe,
  output logic               flashRe,
  input  logic [7:0]         flashRdData,
  output logic [1:0]         laneSel,
  output logic               gateOpen,
  output logic               busy,
  output logic               done,
  output logic [BLOCK_W:0]   bytesWritten,
  output logic [1:0]         errCode
);

  ctlStrobe_t ctl;
  dpFlag_t    flags;

  flash_prog_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .inValid  (inValid),
    .flags    (flags),
    .ctl      (ctl),
    .inReady  (inReady),
    .busy     (busy),
    .done     (done)
  );

  flash_prog_dp #(
    .ADDR_W          (ADDR_W),
    .BLOCK_W         (BLOCK_W),
    .SETTLE_CYC      (SETTLE_CYC),
    .BYTE_TO_CYC     (BYTE_TO_CYC),
    .RETRY_WAIT_CYC  (RETRY_WAIT_CYC),
    .VERIFY_WAIT_CYC (VERIFY_WAIT_CYC),
    .BLOCK_TO_CYC    (BLOCK_TO_CYC)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .startAddr    (startAddr),
    .byteCount    (byteCount),
    .inData       (inData),
    .flashRdData  (flashRdData),
    .flags        (flags),
    .flashAddr    (flashAddr),
    .flashWrData  (flashWrData),
    .flashWe      (flashWe),
    .flashRe      (flashRe),
    .laneSel      (laneSel),
    .bytesWritten (bytesWritten),
    .errCode      (errCode)
  );

  assign gateOpen = ctl.gate;

endmodule

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb_top;

  localparam int ADDR_W  = 12;
  localparam int BLOCK_W = 8;
  localparam int MEM_N   = 1 << ADDR_W;
  localparam int BLK_N   = 1 << BLOCK_W;
  localparam int SETTLE  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [BLOCK_W:0]  byteCount = '0;
  logic [7:0] inData = 8'h00;
  logic inValid = 1'b0;
  logic inReady;
  logic [ADDR_W-1:0] flashAddr;
  logic [7:0] flashWrData, flashRdData;
  logic flashWe, flashRe, gateOpen, busy, done;
  logic [1:0] laneSel, errCode;
  logic [BLOCK_W:0] bytesWritten;

  always #10 clk = ~clk;

  flash_prog_seq dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .byteCount(byteCount), .inData(inData), .inValid(inValid), .inReady(inReady),
    .flashAddr(flashAddr), .flashWrData(flashWrData), .flashWe(flashWe),
    .flashRe(flashRe), .flashRdData(flashRdData), .laneSel(laneSel),
    .gateOpen(gateOpen), .busy(busy), .done(done),
    .bytesWritten(bytesWritten), .errCode(errCode)
  );

  // behavioural flash device
  logic [7:0] fMem [MEM_N];
  logic fReadMode = 1'b1, fExpectData = 1'b0, fHung = 1'b0, fErr = 1'b0;
  int   fReadyCnt = 0;
  int   attemptNo = 0;
  int   opBase = 0, hangN = 0, errN = 0, corruptAddr = -1;

  always_comb begin
    if (fReadMode) flashRdData = fMem[flashAddr];
    else flashRdData = {(!fHung && fReadyCnt == 0), 2'b00, fErr, 4'b0000};
  end

  always @(posedge clk) begin
    if (fReadyCnt > 0) fReadyCnt <= fReadyCnt - 1;
    if (flashWe) begin
      if (fExpectData) begin
        int r;
        int a;
        r = attemptNo - opBase;
        a = {flashAddr[ADDR_W-1:2], laneSel};
        fExpectData <= 1'b0;
        attemptNo   <= attemptNo + 1;
        fReadyCnt   <= 3;
        if (r < hangN) fHung <= 1'b1;
        else if (r < hangN + errN) fErr <= 1'b1;
        else fMem[a] <= (a == corruptAddr) ? (flashWrData ^ 8'h01) : flashWrData;
      end else begin
        case (flashWrData)
          8'h40: begin fExpectData <= 1'b1; fReadMode <= 1'b0; end
          8'h70: fReadMode <= 1'b0;
          8'h50: begin fErr <= 1'b0; fHung <= 1'b0; end
          8'hFF: fReadMode <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // bus monitor: gating, alignment and command counts
  int monWe = 0, mon40 = 0, mon50 = 0, protoErr = 0, sinceGate = 0;
  logic gateArmed = 1'b0, prev40 = 1'b0;
  always @(posedge clk) begin
    if (gateOpen) begin gateArmed <= 1'b1; sinceGate <= 0; end
    else sinceGate <= sinceGate + 1;
    if (flashWe) begin
      monWe <= monWe + 1;
      prev40 <= (!prev40 && flashWrData == 8'h40);
      if (flashAddr[1:0] != 2'b00) protoErr <= protoErr + 1;
      if (!prev40 && (flashWrData == 8'h40 || flashWrData == 8'h50 || flashWrData == 8'hFF)) begin
        if (!gateArmed || sinceGate < SETTLE) protoErr <= protoErr + 1;
        gateArmed <= 1'b0;
        if (flashWrData == 8'h40) mon40 <= mon40 + 1;
        if (flashWrData == 8'h50) mon50 <= mon50 + 1;
      end
    end
  end

  // global watchdog
  int cycles = 0;
  int nChecks = 0, nFails = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 195000) begin
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 195000)", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks + 1, nFails + 1);
      $finish;
    end
  end

  logic [7:0] expMem [MEM_N];
  logic [7:0] pat [512];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expClip(input int addr, input int cnt);
    int room = BLK_N - (addr % BLK_N);
    return (cnt > room) ? room : cnt;
  endfunction

  task automatic runOp(input int addr, input int cnt, input int hang, input int errs,
                       input int corrupt, input int expCode);
    int clip = expClip(addr, cnt);
    int k = 0;
    bit lastReady = 0;
    bit got = 0;
    int we0 = monWe, p0 = protoErr, c40 = mon40, c50 = mon50;
    int expBytes;
    int blk;
    int bad = 0;
    for (int i = 0; i < 512; i++) pat[i] = 8'($urandom);
    opBase = attemptNo; hangN = hang; errN = errs; corruptAddr = corrupt;
    @(negedge clk);
    startAddr = addr[ADDR_W-1:0]; byteCount = cnt[BLOCK_W:0]; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int cyc = 0; cyc < 30000 && !got; cyc++) begin
      if (lastReady) k++;
      if (done) got = 1;
      else begin
        inData = pat[k]; inValid = 1'b1; lastReady = inReady;
        @(negedge clk);
      end
    end
    inValid = 1'b0;
    expBytes = (expCode == 0) ? clip : 0;
    check(got, "R8 done pulse seen", got, 1);
    check(k == clip, "R2 bytes taken from source", k, clip);
    check(int'(bytesWritten) == expBytes, "R1/R8 bytesWritten", bytesWritten, expBytes);
    check(int'(errCode) == expCode, "R6/R7 errCode", errCode, expCode);
    check(!busy, "R8 idle after done", busy, 0);
    if (expCode != 2)
      for (int i = 0; i < clip; i++)
        expMem[addr + i] = (addr + i == corrupt) ? (pat[i] ^ 8'h01) : pat[i];
    blk = addr - (addr % BLK_N);
    @(negedge clk);
    for (int i = 0; i < BLK_N; i++) if (fMem[blk + i] !== expMem[blk + i]) bad++;
    check(bad == 0, "R3 flash image of block", bad, 0);
    check(protoErr == p0, "R3 gate/settle/alignment", protoErr - p0, 0);
    if (clip == 0) check(monWe == we0, "R9 no bus writes", monWe - we0, 0);
    if (expCode == 0) begin
      check(mon40 - c40 == clip + hang + errs, "R4/R5 program attempts", mon40 - c40, clip + hang + errs);
      check(mon50 - c50 == hang + errs, "R4/R5 status clears", mon50 - c50, hang + errs);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < MEM_N; i++) begin fMem[i] = 8'hFF; expMem[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    check(!busy && !done && !inReady, "R8 reset idle", {busy, done, inReady}, 0);
    check(!flashWe && !flashRe && !gateOpen, "R3 reset bus quiet", {flashWe, flashRe, gateOpen}, 0);
    check(bytesWritten == 0 && errCode == 0, "R8 reset results", bytesWritten, 0);
    rstN = 1'b1;
    @(negedge clk);
    runOp(12'h105, 7, 0, 0, -1, 0);     // R3 lanes mid-block
    runOp(12'h2F0, 40, 0, 0, -1, 0);    // R1 clip at boundary
    runOp(12'h300, 256, 0, 0, -1, 0);   // R1 whole block
    runOp(12'h410, 0, 0, 0, -1, 0);     // R9 zero count
    runOp(12'h5FF, 9, 0, 0, -1, 0);     // R1 last byte of block
    runOp(12'h620, 5, 2, 0, -1, 0);     // R4 status timeout retries
    runOp(12'h700, 6, 0, 3, -1, 0);     // R5 device error retries
    runOp(12'h800, 4, 0, 100000, -1, 2);// R6 deadline abort
    runOp(12'h903, 12, 0, 0, 12'h907, 1); // R7 verify mismatch
    for (int n = 0; n < 8; n++)
      runOp($urandom_range(MEM_N - 1, 0), $urandom_range(300, 0), 0, 0, -1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule